// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It handles a small subset of a load/store instruction set: word load, word store, branch-if-equal, and five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than). The core holds the program counter, a 32-entry register file, a sign extender, an ALU and a two-level decoder. Fixed 6-bit opcode and function fields select a fixed set of datapath control lines.

Instruction and data storage are small word arrays inside the core. A load port writes words into either array. While reset is held the program and the initial data are preloaded through this port. A read-back port gives combinational access to any data word, so stored results can be inspected. After reset is released, execution starts at byte address 0.

Top module: `onecycle_cpu`

## Requirements
- R1: While `rst` is high at a rising edge (synchronous, active high), the PC becomes 0, all registers become zero and no data-memory store from the executing instruction takes place. `pc_o` reads 0 after such an edge.
- R2: An instruction with opcode bits[31:26]=000000 is register-type: rs=bits[25:21], rt=bits[20:16], rd=bits[15:11], function=bits[5:0]. Function 100000 writes rs+rt to rd. Function 100010 writes rs-rt. Function 100100 writes rs AND rt. Function 100101 writes rs OR rt.
- R3: Opcode 100011 (load word) writes into rt the data word at byte address rs + sign-extended bits[15:0]. The data memory is indexed by address bits [DA_W+1:2]; higher and lower address bits are ignored.
- R4: Opcode 101011 (store word) writes register rt into the data word at byte address rs + sign-extended bits[15:0], using the same indexing as R3. A store writes no register.
- R5: Opcode 000100 (branch if equal) writes no register. If rs equals rt, the next PC is PC+4+(sign-extended bits[15:0] shifted left by 2). Otherwise it is PC+4. A backward offset is allowed, including -1, which is a self-loop.
- R6: Function 101010 writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R7: Register 0 always reads as zero. Writes to it are discarded.
- R8: Any other opcode, and a register-type word with any other function code, changes neither registers nor data memory and advances the PC by 4.
- R9: Exactly one instruction completes per clock edge. A register written by one instruction is seen by the next instruction.
- R10: When `ld_we` is high at a rising edge, `ld_data` is written to word `ld_addr` of the data array if `ld_to_dmem` is 1, or of the instruction array if it is 0. A load-port write to the data array takes priority over a store in the same cycle. `rb_data` shows data word `rb_addr` combinationally. `pc_o` is the current PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write enable |
| ld_to_dmem | input | 1 | 1 selects the data array, 0 the instruction array |
| ld_addr | input | LD_AW | Word index for a load-port write |
| ld_data | input | 32 | Word written by the load port |
| rb_addr | input | DA_W | Data word index for read-back |
| rb_data | output | 32 | Data word at `rb_addr` |
| pc_o | output | 32 | Current program counter (byte address) |

## Verification
The bench targets signed comparison with a negative operand, where an unsigned compare would return the wrong bit. It targets a load whose base register plus a negative offset lands below the base; an extender that zero-fills would fetch a far-away word instead. It checks that writes to register 0 are discarded, that unknown opcodes and function codes leave state untouched, and that a taken branch skips exactly the intended word. A self-loop branch with offset -1 must hold the PC still; a design that mis-scales the offset or drops the +4 would wander. Back-to-back dependent instructions and random programs with forward branches and register-based addresses are compared word by word against a reference model in the bench.

// File: rtl/ocpu_pkg.sv
package ocpu_pkg;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   localparam logic [5:0] OPC_REG   = 6'b000000;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef struct packed {
      logic    reg_we;
      logic    dst_rd;
      logic    src_imm;
      logic    mem_to_reg;
      logic    mem_we;
      logic    branch;
      alu_op_e alu;
   } ctrl_t;

endpackage

// File: rtl/ocpu_decode.sv
module ocpu_decode
   import ocpu_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   alu_op_e reg_alu;
   logic    reg_known;

   // function-field decoder for register-type words
   always_comb begin
      reg_known = 1'b1;
      case (funct)
         FN_ADD:  reg_alu = ALU_ADD;
         FN_SUB:  reg_alu = ALU_SUB;
         FN_AND:  reg_alu = ALU_AND;
         FN_OR:   reg_alu = ALU_OR;
         FN_SLT:  reg_alu = ALU_SLT;
         default: begin
            reg_alu   = ALU_ADD;
            reg_known = 1'b0;
         end
      endcase
   end

   // opcode decoder
   always_comb begin
      ctrl     = '0;
      ctrl.alu = ALU_ADD;
      case (opcode)
         OPC_REG: begin
            ctrl.reg_we = reg_known;
            ctrl.dst_rd = 1'b1;
            ctrl.alu    = reg_alu;
         end
         OPC_LOAD: begin
            ctrl.reg_we     = 1'b1;
            ctrl.src_imm    = 1'b1;
            ctrl.mem_to_reg = 1'b1;
         end
         OPC_STORE: begin
            ctrl.mem_we  = 1'b1;
            ctrl.src_imm = 1'b1;
         end
         OPC_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.alu    = ALU_SUB;
         end
         default: ;
      endcase
   end

   always_comb begin
      assert_store_no_regwrite_R4: assert (!(ctrl.mem_we && ctrl.reg_we))
         else $error("store word also requests a register write");
   end

endmodule

// File: rtl/ocpu_alu.sv
module ocpu_alu
   import ocpu_pkg::*;
#(
   parameter int XLEN = 32
)(
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y,
   output logic            zero
);

   always_comb begin
      y = '0;
      case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SUB: y = a - b;
         ALU_SLT: y[0] = $signed(a) < $signed(b);
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

   always_comb begin
      if (op == ALU_SUB && a == b)
         assert_equal_sets_zero_R5: assert (zero)
            else $error("equal operands did not raise zero");
   end

endmodule

// File: rtl/ocpu_regfile.sv
module ocpu_regfile #(
   parameter int XLEN           = 32,
   parameter int NREG           = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int RA_W          = $clog2(NREG)
)(
   input  logic            clk,
   input  logic            rst,
   input  logic [RA_W-1:0] ra_a,
   input  logic [RA_W-1:0] ra_b,
   output logic [XLEN-1:0] rd_a,
   output logic [XLEN-1:0] rd_b,
   input  logic            we,
   input  logic [RA_W-1:0] wa,
   input  logic [XLEN-1:0] wd
);

   if (NREG < 2 || (1 << RA_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end

   logic [XLEN-1:0] regs_q [NREG];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
         end else if (we && wa != '0) begin
            regs_q[wa] <= wd;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (!rst && we && wa != '0) regs_q[wa] <= wd;
      end
   end

   assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
   assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];

   assert_write_visible_R9: assert property (@(posedge clk) disable iff (rst)
      (we && wa != '0) |=> (ra_a != $past(wa) || rd_a == $past(wd)));

   assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
      (we && wa == '0) |=> (ra_a != '0 || rd_a == '0));

endmodule

// File: rtl/onecycle_cpu.sv
module onecycle_cpu
   import ocpu_pkg::*;
#(
   parameter int  IMEM_WORDS = 64,
   parameter int  DMEM_WORDS = 64,
   parameter bit  CLEAR_REGS = 1'b1,
   localparam int IA_W       = $clog2(IMEM_WORDS),
   localparam int DA_W       = $clog2(DMEM_WORDS),
   localparam int LD_AW      = (IA_W > DA_W) ? IA_W : DA_W
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_we,
   input  logic             ld_to_dmem,
   input  logic [LD_AW-1:0] ld_addr,
   input  logic [31:0]      ld_data,
   input  logic [DA_W-1:0]  rb_addr,
   output logic [31:0]      rb_data,
   output logic [31:0]      pc_o
);

   if (IMEM_WORDS < 2 || (1 << IA_W) != IMEM_WORDS || IA_W > 29) begin : g_bad_imem
      $error("IMEM_WORDS must be a power of two between 2 and 2**29");
   end
   if (DMEM_WORDS < 2 || (1 << DA_W) != DMEM_WORDS || DA_W > 29) begin : g_bad_dmem
      $error("DMEM_WORDS must be a power of two between 2 and 2**29");
   end

   logic [31:0] imem_q [IMEM_WORDS];
   logic [31:0] dmem_q [DMEM_WORDS];
   logic [31:0] pc_q, pc_plus4, pc_br, instr, signimm;
   logic [31:0] rd_a, rd_b, src_b, alu_y, mem_rd, wb_data;
   logic [4:0]  wr_reg;
   logic        zero, take_br;
   ctrl_t       ctrl;

   assign instr   = imem_q[pc_q[IA_W+1:2]];
   assign signimm = {{16{instr[15]}}, instr[15:0]};

   ocpu_decode u_decode (
      .opcode (instr[31:26]),
      .funct  (instr[5:0]),
      .ctrl   (ctrl)
   );

   ocpu_regfile #(
      .XLEN           (32),
      .NREG           (32),
      .CLEAR_ON_RESET (CLEAR_REGS)
   ) u_regs (
      .clk  (clk),
      .rst  (rst),
      .ra_a (instr[25:21]),
      .ra_b (instr[20:16]),
      .rd_a (rd_a),
      .rd_b (rd_b),
      .we   (ctrl.reg_we),
      .wa   (wr_reg),
      .wd   (wb_data)
   );

   assign src_b = ctrl.src_imm ? signimm : rd_b;

   ocpu_alu #(.XLEN(32)) u_alu (
      .a    (rd_a),
      .b    (src_b),
      .op   (ctrl.alu),
      .y    (alu_y),
      .zero (zero)
   );

   assign mem_rd  = dmem_q[alu_y[DA_W+1:2]];
   assign wb_data = ctrl.mem_to_reg ? mem_rd : alu_y;
   assign wr_reg  = ctrl.dst_rd ? instr[15:11] : instr[20:16];

   assign take_br  = ctrl.branch & zero;
   assign pc_plus4 = pc_q + 32'd4;
   assign pc_br    = pc_plus4 + {signimm[29:0], 2'b00};

   always_ff @(posedge clk) begin
      if (rst)          pc_q <= '0;
      else if (take_br) pc_q <= pc_br;
      else              pc_q <= pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (ld_we && !ld_to_dmem) imem_q[ld_addr[IA_W-1:0]] <= ld_data;
   end

   always_ff @(posedge clk) begin
      if (ld_we && ld_to_dmem)      dmem_q[ld_addr[DA_W-1:0]] <= ld_data;
      else if (ctrl.mem_we && !rst) dmem_q[alu_y[DA_W+1:2]]   <= rd_b;
   end

   assign rb_data = dmem_q[rb_addr];
   assign pc_o    = pc_q;

   logic unused_bits;
   assign unused_bits = ^{instr[10:6], pc_q[31:IA_W+2], pc_q[1:0],
                          alu_y[31:DA_W+2], alu_y[1:0]};

   assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> pc_q == 32'd0);

   assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
      !take_br |=> pc_q == $past(pc_q) + 32'd4);

   assert_branch_target_R5: assert property (@(posedge clk) disable iff (rst)
      take_br |=> pc_q == $past(pc_q) + 32'd4 + {$past(signimm[29:0]), 2'b00});

   assert_beq_no_write_R5: assert property (@(posedge clk) disable iff (rst)
      ctrl.branch |-> !ctrl.reg_we && !ctrl.mem_we);

endmodule

// File: tb/test_onecycle_cpu.sv
module test_onecycle_cpu;

   localparam int W = 64;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_we = 1'b0;
   logic        ld_to_dmem = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [5:0]  rb_addr = '0;
   logic [31:0] rb_data, pc_o;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] prog  [W];
   logic [31:0] dinit [W];
   logic [31:0] m_reg [32];
   logic [31:0] m_mem [W];
   logic [31:0] m_pc;

   always #4 clk = ~clk;

   onecycle_cpu #(.IMEM_WORDS(W), .DMEM_WORDS(W), .CLEAR_REGS(1'b1)) i_onecycle_cpu (
      .clk(clk), .rst(rst), .ld_we(ld_we), .ld_to_dmem(ld_to_dmem),
      .ld_addr(ld_addr), .ld_data(ld_data), .rb_addr(rb_addr),
      .rb_data(rb_data), .pc_o(pc_o)
   );

   function automatic logic [31:0] r_op(int rs, int rt, int rd, logic [5:0] fn);
      return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
   endfunction

   function automatic logic [31:0] i_op(logic [5:0] op, int rs, int rt, int imm);
      return {op, rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rb(int idx, output logic [31:0] v);
      rb_addr = idx[5:0];
      #1;
      v = rb_data;
   endtask

   // reference model, written from the requirements
   task automatic model_run(int n);
      for (int i = 0; i < 32; i++) m_reg[i] = '0;
      for (int i = 0; i < W; i++) m_mem[i] = dinit[i];
      m_pc = '0;
      for (int s = 0; s < n; s++) begin
         logic [31:0] w, a, b, simm, nxt, ea, res;
         logic        ok;
         w    = prog[m_pc[7:2]];
         a    = m_reg[w[25:21]];
         b    = m_reg[w[20:16]];
         simm = {{16{w[15]}}, w[15:0]};
         ea   = a + simm;
         nxt  = m_pc + 32'd4;
         case (w[31:26])
            6'b000000: begin
               ok = 1'b1;
               res = '0;
               case (w[5:0])
                  6'b100000: res = a + b;
                  6'b100010: res = a - b;
                  6'b100100: res = a & b;
                  6'b100101: res = a | b;
                  6'b101010: res = {31'd0, $signed(a) < $signed(b)};
                  default:   ok = 1'b0;
               endcase
               if (ok && w[15:11] != 5'd0) m_reg[w[15:11]] = res;
            end
            6'b100011: if (w[20:16] != 5'd0) m_reg[w[20:16]] = m_mem[ea[7:2]];
            6'b101011: m_mem[ea[7:2]] = b;
            6'b000100: if (a == b) nxt = nxt + {simm[29:0], 2'b00};
            default: ;
         endcase
         m_pc = nxt;
      end
   endtask

   // preload under reset, release, run ncyc instructions, stop at a falling edge
   task automatic run_prog(int ncyc);
      logic [31:0] v;
      rst = 1'b1;
      @(negedge clk);
      for (int i = 0; i < W; i++) begin
         ld_we = 1'b1; ld_to_dmem = 1'b0; ld_addr = i[5:0]; ld_data = prog[i];
         @(negedge clk);
      end
      for (int i = 0; i < W; i++) begin
         ld_we = 1'b1; ld_to_dmem = 1'b1; ld_addr = i[5:0]; ld_data = dinit[i];
         @(negedge clk);
      end
      ld_we = 1'b0;
      @(negedge clk);
      check("R1 pc after reset", pc_o, 32'd0);
      rb(5, v);
      check("R10 preload readback", v, dinit[5]);
      rst = 1'b0;
      repeat (ncyc) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] exp_regs [14];
      void'($urandom(32'd2024));

      // directed program
      for (int i = 0; i < W; i++) begin
         prog[i]  = '0;
         dinit[i] = 32'h1000 + i;
      end
      dinit[0] = 32'hFFFF_FFFB;
      dinit[1] = 32'd3;
      dinit[2] = 32'd8;
      prog[0]  = i_op(6'b100011, 0, 1, 0);
      prog[1]  = i_op(6'b100011, 0, 2, 4);
      prog[2]  = r_op(1, 2, 3, 6'b101010);
      prog[3]  = r_op(2, 1, 4, 6'b101010);
      prog[4]  = r_op(1, 2, 5, 6'b100010);
      prog[5]  = r_op(5, 2, 6, 6'b100000);
      prog[6]  = r_op(1, 2, 7, 6'b100100);
      prog[7]  = r_op(1, 2, 8, 6'b100101);
      prog[8]  = r_op(1, 2, 0, 6'b100000);
      prog[9]  = i_op(6'b100011, 0, 9, 8);
      prog[10] = i_op(6'b100011, 9, 10, -4);
      prog[11] = i_op(6'b001000, 0, 11, 5);
      prog[12] = i_op(6'b000100, 1, 2, 1);
      prog[13] = r_op(2, 2, 12, 6'b100000);
      prog[14] = i_op(6'b000100, 2, 10, 1);
      prog[15] = r_op(2, 2, 13, 6'b100000);
      for (int k = 0; k < 14; k++) prog[16+k] = i_op(6'b101011, 0, k, 4*(30+k));
      prog[30] = i_op(6'b101011, 9, 6, -4);
      prog[31] = i_op(6'b000100, 0, 0, -1);
      exp_regs = '{32'd0, 32'hFFFF_FFFB, 32'd3, 32'd1, 32'd0, 32'hFFFF_FFF8,
                   32'hFFFF_FFFB, 32'd3, 32'hFFFF_FFFB, 32'd8, 32'd3, 32'd0,
                   32'd6, 32'd0};
      run_prog(40);
      check("R5 self-loop holds pc", pc_o, 32'd124);
      rb(30, v); check("R7 r0 ignores write", v, exp_regs[0]);
      rb(31, v); check("R3 load word 0", v, exp_regs[1]);
      rb(32, v); check("R3 load word 1", v, exp_regs[2]);
      rb(33, v); check("R6 slt negative<3", v, exp_regs[3]);
      rb(34, v); check("R6 slt 3<negative", v, exp_regs[4]);
      rb(35, v); check("R2 sub", v, exp_regs[5]);
      rb(36, v); check("R9 dependent add", v, exp_regs[6]);
      rb(37, v); check("R2 and", v, exp_regs[7]);
      rb(38, v); check("R2 or", v, exp_regs[8]);
      rb(39, v); check("R3 load word 2", v, exp_regs[9]);
      rb(40, v); check("R3 negative offset load", v, exp_regs[10]);
      rb(41, v); check("R8 unknown opcode no write", v, exp_regs[11]);
      rb(42, v); check("R5 not-taken branch falls through", v, exp_regs[12]);
      rb(43, v); check("R5 taken branch skips word", v, exp_regs[13]);
      rb(1, v);  check("R4 negative offset store", v, 32'hFFFF_FFFB);
      rb(2, v);  check("R4 untouched word", v, 32'd8);

      // random programs against the model
      for (int p = 0; p < 6; p++) begin
         int k;
         for (int i = 0; i < W; i++) begin
            prog[i]  = '0;
            dinit[i] = $urandom;
         end
         k = 0;
         for (int r = 1; r < 8; r++) begin
            prog[k] = i_op(6'b100011, 0, r, 4*($urandom % 64));
            k++;
         end
         for (int j = 0; j < 30; j++) begin
            int sel;
            logic [5:0] fns [5];
            fns = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
            sel = $urandom % 10;
            if (sel < 5)
               prog[k] = r_op($urandom % 8, $urandom % 8, $urandom % 8, fns[$urandom % 5]);
            else if (sel == 5)
               prog[k] = i_op(6'b100011, $urandom % 8, 1 + $urandom % 7, $urandom);
            else if (sel == 6)
               prog[k] = i_op(6'b101011, $urandom % 8, $urandom % 8, $urandom);
            else if (sel == 7)
               prog[k] = i_op(6'b000100, $urandom % 8, ($urandom % 2 == 0) ? 0 : $urandom % 8,
                              $urandom % 3);
            else if (sel == 8)
               prog[k] = i_op(6'b001101, $urandom % 8, 1 + $urandom % 7, $urandom);
            else
               prog[k] = r_op($urandom % 8, $urandom % 8, 1 + $urandom % 7, 6'b000111);
            k++;
         end
         for (int r = 1; r < 8; r++) begin
            prog[k] = i_op(6'b101011, 0, r, 4*(55+r));
            k++;
         end
         prog[k] = i_op(6'b000100, 0, 0, -1);
         run_prog(k + 8);
         model_run(k + 8);
         check("R5 R9 random final pc", pc_o, m_pc);
         for (int i = 0; i < W; i++) begin
            rb(i, v);
            check("R2 R3 R4 R6 R8 random data word", v, m_mem[i]);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule